// File: doc/BRIEF.md
# Discrete PID Duty Compensator with Load-Line Positioning

This block sits in the control loop of a digitally regulated buck converter and turns one error sample per switching period into a duty-ratio command for the modulator. The error arrives as a small signed code from a windowed converter that compares the output against the reference. A positive code means the output is below the target. The block applies a discrete PID law to that code. The proportional and derivative terms use the present error. The integral term uses the accumulator value from before the present error is added.

With positioning enabled, the regulation target is lowered by an amount proportional to a digitized load-current sample scaled by a programmable resistance code. Under load the output then settles lower, so the converter behaves like a source with a real output impedance. The duty command is rounded from a full-width sum, clamped between zero and a programmable ceiling, and flagged valid a fixed two cycles after the sample strobe. While the command is clamped, the integrator holds its value.

Top module: `pid_duty_core`

## Requirements
- R1: While reset is high and in the cycle after it falls, duty_o is 0 and duty_vld_o is 0. Reset clears the integrator and the stored previous error to 0.
- R2: A sample taken on the rising edge where smp_vld_i is 1 makes duty_vld_o high for exactly the cycle after the second following edge. duty_o changes only in cycles where duty_vld_o is high.
- R3: Gains are signed 8-bit values with 4 fractional bits. The raw command is (kp*e + kd*(e - e_prev) + ki*I + 8) >> 4, using an arithmetic shift (round half up). I is the integrator value before this sample.
- R4: After each unclamped sample the integrator becomes I + e, saturating at the signed 16-bit limits (-32768, 32767).
- R5: err_code_i is a 3-bit two's-complement code where positive means the output is below the reference. The most negative code (3'b100) is used as -3, so the window is symmetric.
- R6: With vpos_en_i = 1, e = code - floor(iload_i * rout_i / 64). With vpos_en_i = 0, e = code.
- R7: duty_o is the raw command clamped to the range 0 to dmax_i. A negative raw command gives 0, and a raw command above dmax_i gives dmax_i.
- R8: A clamped sample leaves the integrator unchanged. The previous-error register still takes e.
- R9: Samples on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Error sample strobe, one per switching period |
| err_code_i | input | 3 | Signed windowed error code (reference minus output) |
| iload_i | input | 8 | Unsigned load-current sample |
| vpos_en_i | input | 1 | Enables the load-dependent target shift |
| rout_i | input | 6 | Output resistance code, scaled by 1/64 |
| kp_i | input | 8 | Proportional gain, signed Q3.4 |
| ki_i | input | 8 | Integral gain, signed Q3.4 |
| kd_i | input | 8 | Derivative gain, signed Q3.4 |
| dmax_i | input | 10 | Upper duty limit |
| duty_o | output | 10 | Duty command for the modulator |
| duty_vld_o | output | 1 | Duty command update strobe |

## Verification
Two things can coincide in one cycle. A new sample can be loaded into the error stage while the previous sample commits its integrator and previous-error update. A clamp decision can also be made in the same cycle as the integrator update it must suppress. The bench drives strobes on consecutive cycles with random gains and ceilings, so stage one and stage two are both busy. Every output is compared, in order, against a reference model that applies the same law sample by sample. Directed samples with large load-current shifts force both clamp directions. The samples that follow expose whether the integrator moved, because ki is made the dominant gain in them.

// File: rtl/pid_pkg.sv
package pid_pkg;

    // Default geometry of the compensator.
    localparam int ERR_W_D    = 3;
    localparam int ILD_W_D    = 8;
    localparam int RO_W_D     = 6;
    localparam int DROOP_SH_D = 6;
    localparam int GAIN_W_D   = 8;
    localparam int FRAC_D     = 4;
    localparam int INT_W_D    = 16;
    localparam int DUTY_W_D   = 10;

    // Outcome of the output limiter for one sample.
    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_LOW  = 2'd1,
        CL_HIGH = 2'd2
    } clamp_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pid_err_stage.sv
module pid_err_stage #(
    parameter int ERR_W    = pid_pkg::ERR_W_D,
    parameter int ILD_W    = pid_pkg::ILD_W_D,
    parameter int RO_W     = pid_pkg::RO_W_D,
    parameter int DROOP_SH = pid_pkg::DROOP_SH_D,
    parameter int EW       = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld_i,
    input  logic [ERR_W-1:0]        err_code_i,
    input  logic [ILD_W-1:0]        iload_i,
    input  logic [RO_W-1:0]         rout_i,
    input  logic                    vpos_en_i,
    output logic signed [EW-1:0]    err_q,
    output logic                    vld_q
);
    localparam int PW = ILD_W + RO_W;
    localparam int DW = PW - DROOP_SH;
    localparam logic [ERR_W-1:0] CODE_MIN = {1'b1, {(ERR_W-1){1'b0}}};
    localparam logic [ERR_W-1:0] CODE_SYM = {1'b1, {(ERR_W-2){1'b0}}, 1'b1};

    logic [ERR_W-1:0]     code_sym;
    logic [PW-1:0]        prod;
    logic [DW-1:0]        droop;
    logic signed [EW-1:0] err_n;

    always_comb begin
        code_sym = (err_code_i == CODE_MIN) ? CODE_SYM : err_code_i;
        prod     = {{RO_W{1'b0}}, iload_i} * {{ILD_W{1'b0}}, rout_i};
        droop    = vpos_en_i ? prod[PW-1:DROOP_SH] : '0;
        err_n    = EW'($signed(code_sym)) - $signed({{(EW-DW){1'b0}}, droop});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= smp_vld_i;
            if (smp_vld_i) begin
                err_q <= err_n;
            end
        end
    end

endmodule

// File: rtl/pid_law_stage.sv
module pid_law_stage #(
    parameter int EW     = 10,
    parameter int GAIN_W = pid_pkg::GAIN_W_D,
    parameter int FRAC   = pid_pkg::FRAC_D,
    parameter int INT_W  = pid_pkg::INT_W_D,
    parameter int DUTY_W = pid_pkg::DUTY_W_D
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      vld_i,
    input  logic signed [EW-1:0]      err_i,
    input  logic signed [GAIN_W-1:0]  kp_i,
    input  logic signed [GAIN_W-1:0]  ki_i,
    input  logic signed [GAIN_W-1:0]  kd_i,
    input  logic [DUTY_W-1:0]         dmax_i,
    output logic [DUTY_W-1:0]         duty_o,
    output logic                      duty_vld_o,
    output logic signed [INT_W-1:0]   integ_q,
    output pid_pkg::clamp_e           clamp_q
);
    import pid_pkg::*;

    localparam int SW = GAIN_W + imax(INT_W, EW + 1) + 2;
    localparam logic signed [SW-1:0] RND = SW'(1) <<< (FRAC - 1);
    localparam logic signed [INT_W-1:0] I_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] I_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic signed [EW-1:0]    prev_q;
    logic signed [SW-1:0]    p_term, d_term, i_term, sum, rnd;
    logic signed [SW-1:0]    dmax_s;
    logic [DUTY_W-1:0]       duty_n;
    clamp_e                  clamp_n;
    logic signed [INT_W:0]   integ_sum;
    logic signed [INT_W-1:0] integ_n;

    always_comb begin
        p_term = SW'(kp_i) * SW'(err_i);
        d_term = SW'(kd_i) * (SW'(err_i) - SW'(prev_q));
        i_term = SW'(ki_i) * SW'(integ_q);
        sum    = p_term + d_term + i_term;
        rnd    = (sum + RND) >>> FRAC;
        dmax_s = $signed({{(SW-DUTY_W){1'b0}}, dmax_i});
        if (rnd < 0) begin
            clamp_n = CL_LOW;
            duty_n  = '0;
        end else if (rnd > dmax_s) begin
            clamp_n = CL_HIGH;
            duty_n  = dmax_i;
        end else begin
            clamp_n = CL_NONE;
            duty_n  = rnd[DUTY_W-1:0];
        end
        integ_sum = (INT_W+1)'(integ_q) + (INT_W+1)'(err_i);
        if (integ_sum[INT_W] != integ_sum[INT_W-1]) begin
            integ_n = integ_sum[INT_W] ? I_MIN : I_MAX;
        end else begin
            integ_n = integ_sum[INT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_o     <= '0;
            duty_vld_o <= 1'b0;
            integ_q    <= '0;
            prev_q     <= '0;
            clamp_q    <= CL_NONE;
        end else begin
            duty_vld_o <= vld_i;
            if (vld_i) begin
                duty_o  <= duty_n;
                clamp_q <= clamp_n;
                prev_q  <= err_i;
                if (clamp_n == CL_NONE) begin
                    integ_q <= integ_n;
                end
            end
        end
    end

endmodule

// File: rtl/pid_duty_core.sv
module pid_duty_core #(
    parameter int ERR_W    = pid_pkg::ERR_W_D,
    parameter int ILD_W    = pid_pkg::ILD_W_D,
    parameter int RO_W     = pid_pkg::RO_W_D,
    parameter int DROOP_SH = pid_pkg::DROOP_SH_D,
    parameter int GAIN_W   = pid_pkg::GAIN_W_D,
    parameter int FRAC     = pid_pkg::FRAC_D,
    parameter int INT_W    = pid_pkg::INT_W_D,
    parameter int DUTY_W   = pid_pkg::DUTY_W_D
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld_i,
    input  logic [ERR_W-1:0]         err_code_i,
    input  logic [ILD_W-1:0]         iload_i,
    input  logic                     vpos_en_i,
    input  logic [RO_W-1:0]          rout_i,
    input  logic signed [GAIN_W-1:0] kp_i,
    input  logic signed [GAIN_W-1:0] ki_i,
    input  logic signed [GAIN_W-1:0] kd_i,
    input  logic [DUTY_W-1:0]        dmax_i,
    output logic [DUTY_W-1:0]        duty_o,
    output logic                     duty_vld_o
);
    import pid_pkg::*;

    // Shifted-error width: the larger of code and droop, plus sign and borrow.
    localparam int DW = ILD_W + RO_W - DROOP_SH;
    localparam int EW = imax(ERR_W, DW) + 2;

    logic signed [EW-1:0]    s1_err;
    logic                    s1_vld;
    logic signed [INT_W-1:0] law_integ;
    clamp_e                  law_clamp;

    pid_err_stage #(
        .ERR_W(ERR_W), .ILD_W(ILD_W), .RO_W(RO_W),
        .DROOP_SH(DROOP_SH), .EW(EW)
    ) err_i (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i),
        .err_code_i(err_code_i), .iload_i(iload_i), .rout_i(rout_i),
        .vpos_en_i(vpos_en_i), .err_q(s1_err), .vld_q(s1_vld)
    );

    pid_law_stage #(
        .EW(EW), .GAIN_W(GAIN_W), .FRAC(FRAC),
        .INT_W(INT_W), .DUTY_W(DUTY_W)
    ) law_i (
        .clk(clk), .rst(rst), .vld_i(s1_vld), .err_i(s1_err),
        .kp_i(kp_i), .ki_i(ki_i), .kd_i(kd_i), .dmax_i(dmax_i),
        .duty_o(duty_o), .duty_vld_o(duty_vld_o),
        .integ_q(law_integ), .clamp_q(law_clamp)
    );

endmodule

// File: rtl/pid_duty_core_chk.sv
module pid_duty_core_chk #(
    parameter int DUTY_W = 10,
    parameter int INT_W  = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_vld_i,
    input logic [DUTY_W-1:0]       dmax_i,
    input logic [DUTY_W-1:0]       duty_o,
    input logic                    duty_vld_o,
    input logic signed [INT_W-1:0] integ_q,
    input pid_pkg::clamp_e         clamp_q
);
    import pid_pkg::*;

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (duty_o == '0 && !duty_vld_o));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (duty_vld_o == $past(smp_vld_i, 2)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !duty_vld_o |-> $stable(duty_o));

    // R7
    ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        duty_vld_o |-> (duty_o <= dmax_i));

    // R7
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_vld_o && clamp_q == CL_LOW) |-> (duty_o == '0));

    // R8
    windup_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_vld_o && clamp_q != CL_NONE) |-> $stable(integ_q));

endmodule

bind pid_duty_core pid_duty_core_chk #(.DUTY_W(DUTY_W), .INT_W(INT_W)) chk_i (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .dmax_i(dmax_i),
    .duty_o(duty_o), .duty_vld_o(duty_vld_o),
    .integ_q(law_integ), .clamp_q(law_clamp)
);

// File: tb/pid_duty_core_tb_top.sv
`timescale 1ns/1ps
module pid_duty_core_tb_top;
    localparam int ERR_W = 3, ILD_W = 8, RO_W = 6, GAIN_W = 8, DUTY_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld_i = 1'b0;
    logic [ERR_W-1:0] err_code_i = '0;
    logic [ILD_W-1:0] iload_i = '0;
    logic vpos_en_i = 1'b0;
    logic [RO_W-1:0] rout_i = '0;
    logic signed [GAIN_W-1:0] kp_i = '0, ki_i = '0, kd_i = '0;
    logic [DUTY_W-1:0] dmax_i = '1;
    logic [DUTY_W-1:0] duty_o;
    logic duty_vld_o;

    always #2.5 clk = ~clk;

    pid_duty_core dut_i (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .err_code_i(err_code_i),
        .iload_i(iload_i), .vpos_en_i(vpos_en_i), .rout_i(rout_i),
        .kp_i(kp_i), .ki_i(ki_i), .kd_i(kd_i), .dmax_i(dmax_i),
        .duty_o(duty_o), .duty_vld_o(duty_vld_o)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    longint m_int = 0;
    longint m_prev = 0;

    int b_code[16];
    int b_ild[16];
    bit b_en[16];
    longint b_exp[16];

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference law: one sample, updates the model state, returns the duty.
    task automatic model_step(input int code, input int ild, input bit en, output longint d);
        longint e, s, r, ni;
        int c;
        c = (code >= 4) ? code - 8 : code;           // R5 two's complement
        if (c == -4) c = -3;                        // R5 symmetric window
        e = c - (en ? ((ild * int'(rout_i)) >> 6) : 0);  // R6
        s = longint'(kp_i) * e + longint'(kd_i) * (e - m_prev) + longint'(ki_i) * m_int; // R3
        r = (s + 8) >>> 4;
        if (r < 0) d = 0;                            // R7
        else if (r > longint'(dmax_i)) d = longint'(dmax_i);
        else begin
            d = r;
            ni = m_int + e;                          // R4
            if (ni > 32767) ni = 32767;
            if (ni < -32768) ni = -32768;
            m_int = ni;
        end                                          // R8 holds when clamped
        m_prev = e;
    endtask

    // Drives n strobes on consecutive cycles and checks each result in order.
    task automatic run_burst(input int n, input string req);
        for (int j = 0; j < n + 3; j++) begin
            if (j < 2) chk("R2 no early valid", duty_vld_o, 0);
            if (j >= 2 && j - 2 < n) begin
                chk("R2 valid strobe", duty_vld_o, 1);
                chk(req, duty_o, b_exp[j-2]);
            end
            if (j == n + 2) begin
                chk("R2 single-cycle valid", duty_vld_o, 0);
                chk("R2 hold", duty_o, b_exp[n-1]);
            end
            if (j < n) begin
                err_code_i = b_code[j][ERR_W-1:0];
                iload_i = b_ild[j][ILD_W-1:0];
                vpos_en_i = b_en[j];
                smp_vld_i = 1'b1;
                model_step(b_code[j], b_ild[j], b_en[j], b_exp[j]);
            end else begin
                smp_vld_i = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic one(input int code, input int ild, input bit en, input string req);
        b_code[0] = code; b_ild[0] = ild; b_en[0] = en;
        run_burst(1, req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset duty", duty_o, 0);
        chk("R1 reset valid", duty_vld_o, 0);
        rst = 1'b0;
        m_int = 0;
        m_prev = 0;
        @(negedge clk);
        chk("R1 duty after reset", duty_o, 0);
        chk("R1 valid after reset", duty_vld_o, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R3 / R5: unity proportional gain, both window ends.
        kp_i = 8'sd16; ki_i = 0; kd_i = 0; dmax_i = 10'd1023; rout_i = 0;
        one(3, 0, 0, "R3 kp*e");
        kp_i = -8'sd16;
        one(4, 0, 0, "R5 extreme code as -3");
        one(3, 0, 0, "R7 negative clamps to 0");
        // R6: positioning shift and its disable.
        rout_i = 6'd32;
        one(0, 128, 1, "R6 droop shift");
        one(0, 128, 0, "R6 disabled");
        // R7 / R8: high clamp with large shift, then expose integrator.
        kp_i = -8'sd128; dmax_i = 10'd500; rout_i = 6'd63;
        one(0, 255, 1, "R7 high clamp");
        kp_i = 0; ki_i = 8'sd16; kd_i = 0; dmax_i = 10'd1023;
        one(3, 0, 0, "R8 integrator after clamp");
        // R3 derivative with rounding.
        kp_i = 0; ki_i = 0; kd_i = 8'sd24;
        one(2, 0, 0, "R3 derivative rounding");
        one(-1 & 7, 0, 0, "R3 derivative negative");

        // R1 again and R4 saturation by long accumulation.
        do_reset();
        kp_i = 0; ki_i = 0; kd_i = 0; dmax_i = 10'd1023; vpos_en_i = 0;
        err_code_i = 3'd3; smp_vld_i = 1'b1;
        for (int i = 0; i < 11000; i++) begin
            longint d;
            model_step(3, 0, 0, d);
            @(negedge clk);
        end
        smp_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        kp_i = 8'sd80; ki_i = 8'sd1; kd_i = 0; rout_i = 6'd63;
        one(0, 255, 1, "R4 integrator saturation");

        // R9: back-to-back strobes with random inputs and gains.
        for (int r = 0; r < 60; r++) begin
            int n;
            n = 1 + int'($urandom % 6);
            kp_i = GAIN_W'(int'($urandom % 96) - 48);
            kd_i = GAIN_W'(int'($urandom % 96) - 48);
            ki_i = GAIN_W'(int'($urandom % 16) - 8);
            dmax_i = ($urandom % 4 == 0) ? DUTY_W'($urandom % 200) : 10'd1023;
            rout_i = RO_W'($urandom);
            for (int k = 0; k < n; k++) begin
                b_code[k] = int'($urandom % 8);
                b_ild[k] = int'($urandom % 256);
                b_en[k] = ($urandom % 2) == 1;
            end
            run_burst(n, "R9 back-to-back result");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule